// File: doc/BRIEF.md
# Parallel Video Capture Window Controller

This block sits behind an 8-bit parallel camera port that runs on the pixel clock. It receives a byte stream along with a frame sync and a line sync, and it counts lines within the frame and bytes within each line. It forwards only the bytes that fall inside a programmable rectangle. Four values set the rectangle: a first line, a number of lines, a first byte and a number of bytes. Byte positions count bytes, not pixels. Each sync input has its own polarity select, so the block works with sensors that drive active-high or active-low syncs.

Capture is frame-based. A frame is only taken when a frame-sync active edge arrives while reception is enabled, so a frame that is already under way when capture is switched on is never taken in part. A busy indication covers the frame from that edge until the last window byte. Three sticky flags record events: the frame completed, the frame sync came back before the window was finished, or a window line ended short. Each flag is gated by its own enable to give an interrupt line. A soft-reset strobe returns the block to idle and clears the flags. The raw sync pin levels are also reported, before any polarity handling.

Top module: `vidcap_window`

## Requirements
- R1: `vsync_pol`/`hsync_pol` pick each sync's active level on their own: 0 means active high and 1 means active low. Only the active level and its edges matter downstream.
- R2: `vsync_raw`/`hsync_raw` report the pin levels as sampled one clock earlier, unaffected by the polarity selects.
- R3: Line 0 is the first active line-sync period after a frame-sync active edge. Byte 0 is the first clock of each active line-sync period. Only clocks with line sync active and frame sync inactive carry bytes.
- R4: A byte at line L, position B is forwarded on `out_data` with `out_valid` high, two clocks after it is presented and in arrival order, exactly when the block is busy, line_start <= L < line_start+line_count and byte_start <= B < byte_start+byte_count.
- R5: Capture starts only at a frame-sync active edge seen while `enable` is high. Raising `enable` part-way through a frame captures nothing from that frame.
- R6: `busy` is 1 from the clock after the starting frame-sync edge until the last window byte is taken, and 0 otherwise.
- R7: `flags[0]` (frame end) is set when the last byte of the window is taken, and `busy` falls at the same clock edge.
- R8: `flags[1]` (vertical error) is set when a frame-sync active edge arrives while still busy. That edge also starts a new frame.
- R9: `flags[2]` (horizontal error) is set when, while busy, a line inside the window's line range ends with fewer than byte_start+byte_count bytes.
- R10: Flags are sticky. A 1 on bit i of `flag_clr` clears flag i only, and a set in the same clock takes priority.
- R11: `irq[i]` equals `flags[i] & irq_en[i]`.
- R12: With `enable` low, `busy` and `out_valid` are 0 from the next clock and the flags hold their values.
- R13: A `soft_reset` pulse clears `busy` and all flags at the next clock and stops forwarding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Reception enable |
| soft_reset | input | 1 | One-clock strobe returning the block to idle |
| vsync_pol | input | 1 | Frame-sync polarity, 1 = active low |
| hsync_pol | input | 1 | Line-sync polarity, 1 = active low |
| vsync_in | input | 1 | Frame-sync pin |
| hsync_in | input | 1 | Line-sync pin |
| pix_in | input | DATA_W | Pixel data byte |
| line_start | input | CNT_W | First captured line |
| line_count | input | CNT_W | Number of captured lines |
| byte_start | input | CNT_W | First captured byte in a line |
| byte_count | input | CNT_W | Number of captured bytes per line |
| flag_clr | input | 3 | Per-flag clear strobes |
| irq_en | input | 3 | Per-flag interrupt enables |
| out_data | output | DATA_W | Forwarded byte |
| out_valid | output | 1 | out_data holds a window byte |
| busy | output | 1 | Frame capture in progress |
| flags | output | 3 | Sticky flags: 0 frame end, 1 vertical error, 2 horizontal error |
| irq | output | 3 | Gated interrupt requests |
| vsync_raw | output | 1 | Registered frame-sync pin level |
| hsync_raw | output | 1 | Registered line-sync pin level |

## Verification
The bench builds the block with its default widths: DATA_W of 8 and CNT_W of 11. At those widths the window sums are computed one bit wider than the window fields. Frames and windows are kept to a few lines and a few tens of bytes, which keeps runs short while still reaching windows that touch or overrun the frame's last line and last byte. Sync polarities are switched between frames, so every combination of active-high and active-low syncs drives the counters.

// File: rtl/vidcap_pkg.sv
package vidcap_pkg;
  localparam int FLAG_N   = 3;
  localparam int FLG_FEND = 0;
  localparam int FLG_VERR = 1;
  localparam int FLG_HERR = 2;

  // active level now and one clock earlier, after polarity
  typedef struct packed {
    logic lvl;
    logic prev;
  } sync_ev_t;
endpackage

// File: rtl/vidcap_sync_in.sv
module vidcap_sync_in
  import vidcap_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        pin,
  input  logic [1:0]        pol,
  input  logic [DATA_W-1:0] pix_in,
  output sync_ev_t          ev [2],
  output logic [1:0]        raw,
  output logic [DATA_W-1:0] data_q
);
  logic [1:0] act_q, act_d;

  for (genvar g = 0; g < 2; g++) begin : g_sync
    always_ff @(posedge clk) begin
      if (rst) begin
        act_q[g] <= 1'b0;
        act_d[g] <= 1'b0;
        raw[g]   <= 1'b0;
      end else begin
        act_q[g] <= pin[g] ^ pol[g];
        act_d[g] <= act_q[g];
        raw[g]   <= pin[g];
      end
    end
    assign ev[g] = '{lvl: act_q[g], prev: act_d[g]};
  end

  always_ff @(posedge clk) data_q <= pix_in;
endmodule

// File: rtl/vidcap_counters.sv
module vidcap_counters
  import vidcap_pkg::*;
#(
  parameter int CNT_W = 11,
  localparam int LW = CNT_W + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  sync_ev_t      vs,
  input  sync_ev_t      hs,
  output logic [LW-1:0] line_idx,
  output logic [LW-1:0] byte_pos,
  output logic [LW-1:0] byte_total
);
  localparam logic [LW-1:0] MAXV = {LW{1'b1}};

  logic [LW-1:0] byte_cnt;
  logic vs_rise, hs_rise, hs_fall, byte_slot;

  assign vs_rise   = vs.lvl & ~vs.prev;
  assign hs_rise   = hs.lvl & ~hs.prev;
  assign hs_fall   = ~hs.lvl & hs.prev;
  assign byte_slot = hs.lvl & ~vs.lvl;
  assign byte_pos  = hs_rise ? '0 : byte_cnt;
  assign byte_total = byte_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_idx <= '0;
      byte_cnt <= '0;
    end else begin
      if (vs_rise)
        line_idx <= '0;
      else if (hs_fall && line_idx != MAXV)
        line_idx <= line_idx + LW'(1);
      if (hs_rise && !byte_slot)
        byte_cnt <= '0;
      else if (byte_slot)
        byte_cnt <= (byte_pos == MAXV) ? MAXV : byte_pos + LW'(1);
    end
  end
endmodule

// File: rtl/vidcap_window_ctl.sv
module vidcap_window_ctl
  import vidcap_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 11,
  localparam int LW = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              soft_reset,
  input  sync_ev_t          vs,
  input  sync_ev_t          hs,
  input  logic [DATA_W-1:0] data_q,
  input  logic [LW-1:0]     line_idx,
  input  logic [LW-1:0]     byte_pos,
  input  logic [LW-1:0]     byte_total,
  input  logic [CNT_W-1:0]  line_start,
  input  logic [CNT_W-1:0]  line_count,
  input  logic [CNT_W-1:0]  byte_start,
  input  logic [CNT_W-1:0]  byte_count,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  output logic              busy,
  output logic [FLAG_N-1:0] evt
);
  logic [LW-1:0] row_lo, row_hi, col_lo, col_hi;
  logic run, active, vs_rise, hs_fall, in_row, in_col, take, last;

  assign row_lo  = LW'(line_start);
  assign row_hi  = LW'(line_start) + LW'(line_count);
  assign col_lo  = LW'(byte_start);
  assign col_hi  = LW'(byte_start) + LW'(byte_count);
  assign run     = enable & ~soft_reset;
  assign vs_rise = vs.lvl & ~vs.prev;
  assign hs_fall = ~hs.lvl & hs.prev;

  always_comb begin
    in_row = (line_idx >= row_lo) && (line_idx < row_hi);
    in_col = (byte_pos >= col_lo) && (byte_pos < col_hi);
    take   = run && active && hs.lvl && !vs.lvl && in_row && in_col;
    last   = take && (line_idx == row_hi - LW'(1)) && (byte_pos == col_hi - LW'(1));
    evt = '0;
    evt[FLG_FEND] = last;
    evt[FLG_VERR] = run && active && vs_rise;
    evt[FLG_HERR] = run && active && hs_fall && in_row && (byte_total < col_hi);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= take;
      if (!run)
        active <= 1'b0;
      else if (vs_rise)
        active <= 1'b1;
      else if (last)
        active <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (take) out_data <= data_q;
  end

  assign busy = active;
endmodule

// File: rtl/vidcap_flags.sv
module vidcap_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear_all,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] en,
  output logic [N-1:0] flags,
  output logic [N-1:0] irq
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst || clear_all)
        flags[i] <= 1'b0;
      else if (set[i])
        flags[i] <= 1'b1;
      else if (clr[i])
        flags[i] <= 1'b0;
    end
    assign irq[i] = flags[i] & en[i];
  end
endmodule

// File: rtl/vidcap_window.sv
module vidcap_window
  import vidcap_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 11,
  localparam int LW = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              soft_reset,
  input  logic              vsync_pol,
  input  logic              hsync_pol,
  input  logic              vsync_in,
  input  logic              hsync_in,
  input  logic [DATA_W-1:0] pix_in,
  input  logic [CNT_W-1:0]  line_start,
  input  logic [CNT_W-1:0]  line_count,
  input  logic [CNT_W-1:0]  byte_start,
  input  logic [CNT_W-1:0]  byte_count,
  input  logic [2:0]        flag_clr,
  input  logic [2:0]        irq_en,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  output logic              busy,
  output logic [2:0]        flags,
  output logic [2:0]        irq,
  output logic              vsync_raw,
  output logic              hsync_raw
);
  sync_ev_t          ev [2];
  logic [1:0]        raw;
  logic [DATA_W-1:0] data_q;
  logic [LW-1:0]     line_idx, byte_pos, byte_total;
  logic [FLAG_N-1:0] evt;
  logic              vs_rise_w;

  vidcap_sync_in #(.DATA_W(DATA_W)) u_sync (
    .clk(clk), .rst(rst),
    .pin({hsync_in, vsync_in}), .pol({hsync_pol, vsync_pol}),
    .pix_in(pix_in), .ev(ev), .raw(raw), .data_q(data_q)
  );

  vidcap_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .vs(ev[0]), .hs(ev[1]),
    .line_idx(line_idx), .byte_pos(byte_pos), .byte_total(byte_total)
  );

  vidcap_window_ctl #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_ctl (
    .clk(clk), .rst(rst), .enable(enable), .soft_reset(soft_reset),
    .vs(ev[0]), .hs(ev[1]), .data_q(data_q),
    .line_idx(line_idx), .byte_pos(byte_pos), .byte_total(byte_total),
    .line_start(line_start), .line_count(line_count),
    .byte_start(byte_start), .byte_count(byte_count),
    .out_data(out_data), .out_valid(out_valid), .busy(busy), .evt(evt)
  );

  vidcap_flags #(.N(FLAG_N)) u_flags (
    .clk(clk), .rst(rst), .clear_all(soft_reset),
    .set(evt), .clr(flag_clr), .en(irq_en),
    .flags(flags), .irq(irq)
  );

  assign vsync_raw = raw[0];
  assign hsync_raw = raw[1];
  assign vs_rise_w = ev[0].lvl & ~ev[0].prev;
endmodule

// File: rtl/vidcap_window_chk.sv
module vidcap_window_chk (
  input logic       clk,
  input logic       rst,
  input logic       enable,
  input logic       soft_reset,
  input logic       busy,
  input logic       out_valid,
  input logic [2:0] flags,
  input logic [2:0] flag_clr,
  input logic       vs_rise
);
  assert_out_needs_busy_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(busy));

  assert_start_on_vsync_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(vs_rise));

  assert_fend_ends_busy_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(flags[0]) |-> $fell(busy));

  assert_verr_while_busy_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(flags[1]) |-> ($past(busy) && busy));

  assert_flags_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    ((($past(flags) & ~flags) & ~$past(flag_clr)) == 3'b000) || $past(soft_reset));

  assert_disable_idle_R12: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!busy && !out_valid));

  assert_soft_reset_R13: assert property (@(posedge clk) disable iff (rst)
    soft_reset |=> (flags == 3'b000 && !busy));
endmodule

bind vidcap_window vidcap_window_chk u_chk (
  .clk(clk), .rst(rst), .enable(enable), .soft_reset(soft_reset),
  .busy(busy), .out_valid(out_valid), .flags(flags),
  .flag_clr(flag_clr), .vs_rise(vs_rise_w)
);

// File: tb/test_vidcap_window.sv
`timescale 1ns/1ps
module test_vidcap_window;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0, soft_reset = 1'b0;
  logic vsync_pol = 1'b0, hsync_pol = 1'b0;
  logic vsync_in = 1'b0, hsync_in = 1'b0;
  logic [7:0] pix_in = '0;
  logic [10:0] line_start = '0, line_count = '0, byte_start = '0, byte_count = '0;
  logic [2:0] flag_clr = '0, irq_en = '0;
  logic [7:0] out_data;
  logic out_valid, busy, vsync_raw, hsync_raw;
  logic [2:0] flags, irq;

  int checks = 0, errors = 0;
  bit done = 0;
  int m_ls, m_lc, m_bs, m_bc;
  bit m_active = 0;
  bit [2:0] m_flags = '0;
  logic [7:0] exp_q[$], got_q[$];

  always #2.5 clk = ~clk;

  vidcap_window i_vidcap_window (
    .clk(clk), .rst(rst), .enable(enable), .soft_reset(soft_reset),
    .vsync_pol(vsync_pol), .hsync_pol(hsync_pol),
    .vsync_in(vsync_in), .hsync_in(hsync_in), .pix_in(pix_in),
    .line_start(line_start), .line_count(line_count),
    .byte_start(byte_start), .byte_count(byte_count),
    .flag_clr(flag_clr), .irq_en(irq_en),
    .out_data(out_data), .out_valid(out_valid), .busy(busy),
    .flags(flags), .irq(irq), .vsync_raw(vsync_raw), .hsync_raw(hsync_raw)
  );

  always @(negedge clk) if (!rst && out_valid) got_q.push_back(out_data);

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      vsync_in = vsync_pol;
      hsync_in = hsync_pol;
    end
  endtask

  task automatic set_pol(input bit v, input bit h);
    @(negedge clk);
    vsync_pol = v; hsync_pol = h;
    vsync_in = v;  hsync_in = h;
  endtask

  task automatic set_win(input int ls, input int lc, input int bs, input int bc);
    @(negedge clk);
    m_ls = ls; m_lc = lc; m_bs = bs; m_bc = bc;
    line_start = 11'(ls); line_count = 11'(lc);
    byte_start = 11'(bs); byte_count = 11'(bc);
  endtask

  task automatic clear_flags(input bit [2:0] m);
    @(negedge clk) flag_clr = m;
    @(negedge clk) flag_clr = '0;
    m_flags = m_flags & ~m;
  endtask

  // kind: 0 none, 1 enable at line, 2 disable at line, 3 soft reset at line
  task automatic send_frame(input int nl, input int nb, input int kind, input int cline);
    if (enable) begin
      if (m_active) m_flags[1] = 1'b1;
      m_active = 1'b1;
    end
    repeat (2) begin @(negedge clk); vsync_in = ~vsync_pol; hsync_in = hsync_pol; end
    idle(2);
    check("R6 busy after frame sync edge", busy, m_active);
    for (int l = 0; l < nl; l++) begin
      if (l == cline) begin
        if (kind == 1) begin @(negedge clk) enable = 1'b1; end
        if (kind == 2) begin @(negedge clk) enable = 1'b0; m_active = 0; end
        if (kind == 3) begin
          @(negedge clk) soft_reset = 1'b1;
          @(negedge clk) soft_reset = 1'b0;
          m_active = 0; m_flags = '0;
        end
      end
      for (int b = 0; b < nb; b++) begin
        @(negedge clk);
        hsync_in = ~hsync_pol;
        pix_in = 8'($urandom);
        if (m_active && l >= m_ls && l < m_ls + m_lc && b >= m_bs && b < m_bs + m_bc) begin
          exp_q.push_back(pix_in);
          if (l == m_ls + m_lc - 1 && b == m_bs + m_bc - 1) begin
            m_flags[0] = 1'b1;
            m_active = 0;
          end
        end
      end
      idle(3);
      if (m_active && l >= m_ls && l < m_ls + m_lc && nb < m_bs + m_bc) m_flags[2] = 1'b1;
    end
    idle(4);
  endtask

  task automatic check_frame(input string tag);
    int mism = 0;
    check({"R4 byte count ", tag}, got_q.size(), exp_q.size());
    if (got_q.size() == exp_q.size())
      foreach (exp_q[i]) if (got_q[i] !== exp_q[i]) mism++;
    check({"R3 window byte content ", tag}, mism, 0);
    check({"R6 busy at frame end ", tag}, busy, m_active);
    check({"R7 frame end flag ", tag}, flags[0], m_flags[0]);
    check({"R8 vertical error flag ", tag}, flags[1], m_flags[1]);
    check({"R9 horizontal error flag ", tag}, flags[2], m_flags[2]);
    check({"R11 irq ", tag}, irq, m_flags & irq_en);
    got_q.delete();
    exp_q.delete();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("reset busy", busy, 0);
    check("reset flags", flags, 0);
    check("reset out_valid", out_valid, 0);
    check("reset irq", irq, 0);

    // R2: raw pin levels, independent of polarity
    set_pol(1'b1, 1'b0);
    @(negedge clk); vsync_in = 1'b0; hsync_in = 1'b1;
    @(negedge clk);
    check("R2 vsync_raw low", vsync_raw, 0);
    check("R2 hsync_raw high", hsync_raw, 1);
    @(negedge clk); vsync_in = 1'b1; hsync_in = 1'b0;
    @(negedge clk);
    check("R2 vsync_raw high", vsync_raw, 1);
    check("R2 hsync_raw low", hsync_raw, 0);
    set_pol(1'b0, 1'b0);
    idle(3);

    irq_en = 3'b111;
    enable = 1'b1;
    set_win(1, 2, 2, 3);
    send_frame(5, 8, 0, -1);  check_frame("basic");
    // R1: polarity variants
    set_pol(1'b1, 1'b1); send_frame(5, 8, 0, -1); check_frame("R1 both low");
    set_pol(1'b0, 1'b1); send_frame(5, 8, 0, -1); check_frame("R1 mixed");
    clear_flags(3'b111);
    check("R10 clear all", flags, 0);
    // R5: enable during frame captures nothing
    @(negedge clk) enable = 1'b0;
    send_frame(5, 8, 1, 1); check_frame("R5 late enable");
    send_frame(5, 8, 0, -1); check_frame("R5 next frame");
    // window touches frame edges exactly
    set_win(0, 5, 0, 8);
    send_frame(5, 8, 0, -1); check_frame("full frame window");
    clear_flags(3'b001);
    // R9 then R8: window wider than line
    set_win(0, 2, 4, 10);
    send_frame(4, 8, 0, -1); check_frame("R9 short line");
    send_frame(4, 8, 0, -1); check_frame("R8 frame restarts");
    // R10: clear one flag only
    clear_flags(3'b100);
    check("R10 herr cleared", flags[2], 0);
    check("R10 verr kept", flags[1], 1);
    @(negedge clk) irq_en = 3'b001;
    @(negedge clk);
    check("R11 irq masked", irq, m_flags & 3'b001);
    irq_en = 3'b111;
    // R12: disable mid-frame
    set_win(1, 3, 0, 4);
    send_frame(5, 6, 2, 2); check_frame("R12 disabled");
    @(negedge clk) enable = 1'b1;
    // R13: soft reset mid-frame
    send_frame(5, 6, 3, 2); check_frame("R13 soft reset");
    check("R13 flags zero", flags, 0);

    for (int k = 0; k < 14; k++) begin
      int nl, nb;
      set_pol(1'($urandom), 1'($urandom));
      nl = 1 + int'($urandom % 7);
      nb = 1 + int'($urandom % 16);
      set_win(int'($urandom % 4), 1 + int'($urandom % 5),
              int'($urandom % 8), 1 + int'($urandom % 8));
      @(negedge clk) irq_en = 3'($urandom);
      send_frame(nl, nb, 0, -1);
      check_frame("random");
      if ($urandom % 2) clear_flags(3'($urandom));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule